// File: doc/BRIEF.md
# SDRAM Concurrent Auto-Precharge Bank Tracker

This block sits inside an SDRAM controller for a four-bank mobile SDRAM. It follows every command the controller registers and keeps a state machine for each bank. When a READ or WRITE to one bank lands while another bank's burst is still in flight, the tracker works out three things:

- when the older burst's data stops;
- when the older bank's automatic precharge begins, if that burst asked for one;
- how many clocks of data-mask lead a WRITE needs in order to keep the data bus free of contention.

The controller supplies the command, the auto-precharge flag, the bank, the CAS latency choice and the write-recovery time. The tracker returns the state of each bank, a one-clock precharge-start pulse per bank, the required mask lead, and a data-beat window that names the bank and direction of the data at each clock edge. It also returns a flag for any command that is not legal in the addressed bank's state.

Each bank runs through six named states:

| State | Code |
|---|---|
| IDLE | 0 |
| OPEN | 1 |
| READ | 2 |
| WRITE | 3 |
| WREC | 4 |
| PRECH | 5 |

The transitions are named as follows:

- IDLE→OPEN on ACTIVE.
- OPEN→READ or OPEN→WRITE on a transfer.
- READ/WRITE→READ/WRITE on a same-bank transfer.
- READ/WRITE→OPEN on burst end or burst stop.
- READ→PRECH on an auto-precharge read that ends or is cut off.
- WRITE→WREC on an auto-precharge write that ends or is cut off.
- WREC→PRECH when write recovery has elapsed.
- OPEN→PRECH on PRECHARGE.
- PRECH→IDLE after the precharge time.

Top module: `sdr_bank_tracker`

## Requirements
- R1: After reset every bank reads IDLE (0), and all pulses, the mask lead, the beat window and the illegal flag are 0.
- R2: Command codes are: 0 none, 1 ACTIVE, 2 READ, 3 WRITE, 4 BURST STOP, 5 PRECHARGE, and 6–7 reserved. The table below gives the states in which each command is legal. Any other pairing raises illegal_o in the clock after the edge it was registered on and changes no bank state.

| Command | Legal when the addressed bank is |
|---|---|
| none | always |
| ACTIVE | IDLE |
| READ or WRITE | OPEN, or READ/WRITE without auto precharge |
| PRECHARGE | OPEN |
| BURST STOP | READ/WRITE without auto precharge, while no other bank is in READ/WRITE |
| 6–7 | never |

- R3: ACTIVE moves a bank from IDLE to OPEN. PRECHARGE moves it to PRECH, and it returns to IDLE T_RP edges later, after which a new ACTIVE is needed before any access.
- R4: A READ registered at edge t places data beats at edges t+CL … t+CL+BL−1. CL is 3 when cl3_i is 1 and 2 when it is 0. A WRITE places beats at edges t … t+BL−1. After each beat edge, dvalid_o is 1, drd_o gives the direction (1 = read) and dbank_o gives the bank.
- R5: A READ to bank m at edge t cuts off a read burst of bank n so that bank n's last beat is at edge t+CL−1.
- R6: A WRITE at edge t removes every pending beat, so no older read beat appears at or after edge t.
- R7: A READ or WRITE at edge t that cuts off a write burst leaves that burst's last beat at edge t−1.
- R8: dqm_lead_o is 2 while any bank is in READ with auto precharge. Otherwise it is 1 while any bank is in READ. Otherwise it is 0.
- R9: A READ with auto precharge that is cut off at edge t by a transfer to another bank enters PRECH at edge t, with its precharge-start pulse in the following clock.
- R10: A WRITE with auto precharge that is cut off at edge t by a transfer to another bank enters WREC at edge t and PRECH at edge t+tWR.
- R11: A burst that is not cut off ends at its last beat edge. Without auto precharge the bank goes to OPEN. A read with auto precharge goes to PRECH. A write with auto precharge goes to WREC and reaches PRECH tWR edges later.
- R12: A legal BURST STOP returns its bank to OPEN at that edge and removes all pending beats.
- R13: Each precharge-start pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Registered command code (R2) |
| ap_i | input | 1 | Auto-precharge flag for READ/WRITE |
| bank_i | input | 2 | Addressed bank |
| cl3_i | input | 1 | CAS latency select: 1 = 3 clocks, 0 = 2 clocks |
| twr_i | input | 3 | Write recovery time in clocks (0 treated as 1) |
| bank_state_o | output | 12 | State code of bank b at bits 3b+2:3b |
| pre_start_o | output | 4 | Per-bank precharge-start pulse |
| dqm_lead_o | output | 2 | Clocks of mask lead a WRITE issued now needs |
| dvalid_o | output | 1 | A data beat took place at the last edge |
| drd_o | output | 1 | That beat was read data |
| dbank_o | output | 2 | Bank that owns that beat |
| illegal_o | output | 1 | Last registered command was illegal |

## Verification
The bench covers all four interrupt pairings, each run once with and once without auto precharge on the interrupted bank. It samples the exact edge at which the old data stops, the edge at which the old bank's precharge pulse fires, and the mask lead seen before the interrupting command.

A design that let a read finish its full burst would show an extra old-bank beat at t+CL. One that left write beats in place after a READ interrupt would show old write data at edge t. One that started a cut-off write's precharge at once, instead of after tWR, would pulse two clocks early.

Burst stop aimed at a bank that holds no burst, and accesses to a closed bank, must be flagged without disturbing any bank. A constrained-random phase of open, close, stop and reserved commands compares every bank state and the illegal flag against a bench model after each edge.

// File: rtl/sdr_trk_pkg.sv
package sdr_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4,
        CMD_PRE = 3'd5
    } cmd_e;

    typedef enum logic [2:0] {
        BS_IDLE  = 3'd0,
        BS_OPEN  = 3'd1,
        BS_READ  = 3'd2,
        BS_WRITE = 3'd3,
        BS_WREC  = 3'd4,
        BS_PRECH = 3'd5
    } bstate_e;

endpackage

// File: rtl/sdr_cmd_check.sv
module sdr_cmd_check
    import sdr_trk_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic [2:0]            cmd_i,
    input  logic [$clog2(NB)-1:0] bank_i,
    input  bstate_e               st_i [NB],
    input  logic [NB-1:0]         bap_i,
    output logic                  act_go_o,
    output logic                  rd_go_o,
    output logic                  wr_go_o,
    output logic                  bst_go_o,
    output logic                  pre_go_o,
    output logic                  illegal_o
);

    bstate_e tgt;
    logic    busy_other;
    logic    legal;
    logic    tgt_burst;

    always_comb begin
        tgt        = st_i[bank_i];
        tgt_burst  = (tgt == BS_READ) || (tgt == BS_WRITE);
        busy_other = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (b != int'(bank_i) && (st_i[b] == BS_READ || st_i[b] == BS_WRITE))
                busy_other = 1'b1;
        end
        unique case (cmd_i)
            CMD_NOP:         legal = 1'b1;
            CMD_ACT:         legal = (tgt == BS_IDLE);
            CMD_RD, CMD_WR:  legal = (tgt == BS_OPEN) || (tgt_burst && !bap_i[bank_i]);
            CMD_BST:         legal = tgt_burst && !bap_i[bank_i] && !busy_other;
            CMD_PRE:         legal = (tgt == BS_OPEN);
            default:         legal = 1'b0;
        endcase
    end

    assign act_go_o  = legal && (cmd_i == CMD_ACT);
    assign rd_go_o   = legal && (cmd_i == CMD_RD);
    assign wr_go_o   = legal && (cmd_i == CMD_WR);
    assign bst_go_o  = legal && (cmd_i == CMD_BST);
    assign pre_go_o  = legal && (cmd_i == CMD_PRE);
    assign illegal_o = !legal;

endmodule

// File: rtl/sdr_beat_sched.sv
module sdr_beat_sched #(
    parameter int NB     = 4,
    parameter int BL     = 4,
    parameter int CL_MAX = 3
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          rd_go_i,
    input  logic                          wr_go_i,
    input  logic                          bst_go_i,
    input  logic [$clog2(NB)-1:0]         bank_i,
    input  logic [$clog2(CL_MAX+1)-1:0]   cl_i,
    output logic [NB-1:0]                 pend_o,
    output logic                          beat_v_o,
    output logic                          beat_rd_o,
    output logic [$clog2(NB)-1:0]         beat_bk_o
);

    localparam int BW    = $clog2(NB);
    localparam int DEPTH = CL_MAX + BL;

    // slot j holds the beat for the edge j clocks after the coming one
    logic [DEPTH-1:0]         s_v, s_rd, n_v, n_rd;
    logic [DEPTH-1:0][BW-1:0] s_bk, n_bk;
    int                       cl_n;

    always_comb begin
        cl_n = int'(cl_i);
        n_v  = s_v;
        n_rd = s_rd;
        n_bk = s_bk;
        for (int j = 0; j < DEPTH; j++) begin
            if (wr_go_i || bst_go_i) n_v[j] = 1'b0;
            if (rd_go_i && (j >= cl_n || !s_rd[j])) n_v[j] = 1'b0;
            if (rd_go_i && j >= cl_n && j < cl_n + BL) begin
                n_v[j]  = 1'b1;
                n_rd[j] = 1'b1;
                n_bk[j] = bank_i;
            end
            if (wr_go_i && j < BL) begin
                n_v[j]  = 1'b1;
                n_rd[j] = 1'b0;
                n_bk[j] = bank_i;
            end
        end
        pend_o = '0;
        for (int j = 1; j < DEPTH; j++) begin
            if (n_v[j]) pend_o[n_bk[j]] = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_v       <= '0;
            s_rd      <= '0;
            s_bk      <= '0;
            beat_v_o  <= 1'b0;
            beat_rd_o <= 1'b0;
            beat_bk_o <= '0;
        end else begin
            s_v       <= {1'b0, n_v[DEPTH-1:1]};
            s_rd      <= {1'b0, n_rd[DEPTH-1:1]};
            s_bk      <= {{BW{1'b0}}, n_bk[DEPTH-1:1]};
            beat_v_o  <= n_v[0];
            beat_rd_o <= n_v[0] & n_rd[0];
            beat_bk_o <= n_v[0] ? n_bk[0] : '0;
        end
    end

    // R6: a write owns the bus from its own edge
    p_write_cut_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_go_i |=> (beat_v_o && !beat_rd_o));

endmodule

// File: rtl/sdr_bank_fsm.sv
module sdr_bank_fsm
    import sdr_trk_pkg::*;
#(
    parameter int T_RP  = 2,
    parameter int TWR_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sel_i,
    input  logic             act_go_i,
    input  logic             rd_go_i,
    input  logic             wr_go_i,
    input  logic             bst_go_i,
    input  logic             pre_go_i,
    input  logic             ap_i,
    input  logic             pend_i,
    input  logic [TWR_W-1:0] twr_i,
    output bstate_e          state_o,
    output logic             ap_o,
    output logic             pre_start_o
);

    localparam int RPW = $clog2(T_RP + 1);
    localparam int CW  = (TWR_W > RPW) ? TWR_W : RPW;
    localparam logic [CW-1:0] RP_LOAD = CW'(T_RP - 1);

    bstate_e       state, nxt;
    logic          nap, enter_pre, other_xfer, own_xfer;
    logic [CW-1:0] cnt, ncnt, tw, twr_load;

    assign tw         = CW'(twr_i);
    assign twr_load   = (tw == '0) ? '0 : tw - CW'(1);
    assign own_xfer   = sel_i && (rd_go_i || wr_go_i);
    assign other_xfer = !sel_i && (rd_go_i || wr_go_i);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state       <= BS_IDLE;
            ap_o        <= 1'b0;
            cnt         <= '0;
            pre_start_o <= 1'b0;
        end else begin
            state       <= nxt;
            ap_o        <= nap;
            cnt         <= ncnt;
            pre_start_o <= enter_pre;
        end
    end

    always_comb begin
        nxt       = state;
        nap       = ap_o;
        ncnt      = cnt;
        enter_pre = 1'b0;
        unique case (state)
            BS_IDLE: if (sel_i && act_go_i) nxt = BS_OPEN;
            BS_OPEN: begin
                if (own_xfer) begin
                    nxt = rd_go_i ? BS_READ : BS_WRITE;
                    nap = ap_i;
                end else if (sel_i && pre_go_i) begin
                    nxt       = BS_PRECH;
                    ncnt      = RP_LOAD;
                    enter_pre = 1'b1;
                end
            end
            BS_READ, BS_WRITE: begin
                if (own_xfer) begin
                    nxt = rd_go_i ? BS_READ : BS_WRITE;
                    nap = ap_i;
                end else if (sel_i && bst_go_i) begin
                    nxt = BS_OPEN;
                end else if (ap_o && (other_xfer || !pend_i)) begin
                    if (state == BS_READ) begin
                        nxt       = BS_PRECH;
                        ncnt      = RP_LOAD;
                        enter_pre = 1'b1;
                    end else begin
                        nxt  = BS_WREC;
                        ncnt = twr_load;
                    end
                end else if (!pend_i) begin
                    nxt = BS_OPEN;
                end
            end
            BS_WREC: begin
                if (cnt == '0) begin
                    nxt       = BS_PRECH;
                    ncnt      = RP_LOAD;
                    enter_pre = 1'b1;
                end else begin
                    ncnt = cnt - CW'(1);
                end
            end
            BS_PRECH: begin
                if (cnt == '0) nxt = BS_IDLE;
                else           ncnt = cnt - CW'(1);
            end
            default: nxt = BS_IDLE;
        endcase
    end

    assign state_o = state;

    p_pulse_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pre_start_o |=> !pre_start_o);

    p_idle_needs_act_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == BS_IDLE && !(sel_i && act_go_i)) |=> state == BS_IDLE);

    p_wrec_exit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state == BS_WREC |=> (state == BS_WREC || state == BS_PRECH));

endmodule

// File: rtl/sdr_bank_tracker.sv
module sdr_bank_tracker
    import sdr_trk_pkg::*;
#(
    parameter int NB     = 4,
    parameter int BL     = 4,
    parameter int CL_MAX = 3,
    parameter int T_RP   = 2,
    parameter int TWR_W  = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [2:0]            cmd_i,
    input  logic                  ap_i,
    input  logic [$clog2(NB)-1:0] bank_i,
    input  logic                  cl3_i,
    input  logic [TWR_W-1:0]      twr_i,
    output logic [NB*3-1:0]       bank_state_o,
    output logic [NB-1:0]         pre_start_o,
    output logic [1:0]            dqm_lead_o,
    output logic                  dvalid_o,
    output logic                  drd_o,
    output logic [$clog2(NB)-1:0] dbank_o,
    output logic                  illegal_o
);

    localparam int BW  = $clog2(NB);
    localparam int CLW = $clog2(CL_MAX + 1);

    bstate_e          st [NB];
    logic [NB-1:0]    bap, pend;
    logic             act_go, rd_go, wr_go, bst_go, pre_go, illegal;
    logic [CLW-1:0]   cl_val;

    assign cl_val = cl3_i ? CLW'(3) : CLW'(2);

    sdr_cmd_check #(.NB(NB)) u_check (
        .cmd_i     (cmd_i),
        .bank_i    (bank_i),
        .st_i      (st),
        .bap_i     (bap),
        .act_go_o  (act_go),
        .rd_go_o   (rd_go),
        .wr_go_o   (wr_go),
        .bst_go_o  (bst_go),
        .pre_go_o  (pre_go),
        .illegal_o (illegal)
    );

    sdr_beat_sched #(.NB(NB), .BL(BL), .CL_MAX(CL_MAX)) u_sched (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rd_go_i   (rd_go),
        .wr_go_i   (wr_go),
        .bst_go_i  (bst_go),
        .bank_i    (bank_i),
        .cl_i      (cl_val),
        .pend_o    (pend),
        .beat_v_o  (dvalid_o),
        .beat_rd_o (drd_o),
        .beat_bk_o (dbank_o)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        sdr_bank_fsm #(.T_RP(T_RP), .TWR_W(TWR_W)) u_fsm (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .sel_i       (bank_i == BW'(b)),
            .act_go_i    (act_go),
            .rd_go_i     (rd_go),
            .wr_go_i     (wr_go),
            .bst_go_i    (bst_go),
            .pre_go_i    (pre_go),
            .ap_i        (ap_i),
            .pend_i      (pend[b]),
            .twr_i       (twr_i),
            .state_o     (st[b]),
            .ap_o        (bap[b]),
            .pre_start_o (pre_start_o[b])
        );
        assign bank_state_o[b*3 +: 3] = st[b];
    end

    always_comb begin
        dqm_lead_o = 2'd0;
        for (int b = 0; b < NB; b++) begin
            if (st[b] == BS_READ) begin
                if (bap[b])                  dqm_lead_o = 2'd2;
                else if (dqm_lead_o == 2'd0) dqm_lead_o = 2'd1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) illegal_o <= 1'b0;
        else         illegal_o <= illegal;
    end

    // R12: a legal burst stop leaves no beat on the following edge
    p_bst_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bst_go |=> !dvalid_o);

endmodule

// File: tb/sdr_bank_tracker_tb.sv
module sdr_bank_tracker_tb_top;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                           C_BST = 3'd4, C_PRE = 3'd5;
    localparam int S_IDLE = 0, S_OPEN = 1, S_READ = 2, S_WREC = 4, S_PRECH = 5;
    localparam int TRP = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cmd;
    logic       ap;
    logic [1:0] bank;
    logic       cl3;
    logic [2:0] twr;
    logic [11:0] bank_state;
    logic [3:0]  pre_start;
    logic [1:0]  dqm_lead;
    logic        dvalid, drd, illegal;
    logic [1:0]  dbank;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    sdr_bank_tracker dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .ap_i(ap), .bank_i(bank),
        .cl3_i(cl3), .twr_i(twr), .bank_state_o(bank_state), .pre_start_o(pre_start),
        .dqm_lead_o(dqm_lead), .dvalid_o(dvalid), .drd_o(drd), .dbank_o(dbank),
        .illegal_o(illegal)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int st(input int b);
        return int'(bank_state[b*3 +: 3]);
    endfunction

    function automatic int beat(input int v, input int rd, input int bk);
        return v * 100 + rd * 10 + bk;
    endfunction

    function automatic int obs_beat();
        return beat(int'(dvalid), int'(drd), int'(dbank));
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [2:0] c, input int b, input logic a);
        cmd = c; bank = 2'(b); ap = a;
        @(posedge clk);
        @(negedge clk);
        cmd = C_NOP; ap = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd = C_NOP; ap = 1'b0; bank = 2'd0; cl3 = 1'b1; twr = 3'd2;
        tick(2);
        rst_n = 1'b1;
    endtask

    // read on bank 0 cut off by read on bank 1
    task automatic run_rr(input int apn);
        do_reset();
        issue(C_ACT, 0, 0); issue(C_ACT, 1, 0);
        issue(C_RD, 0, 1'(apn));
        chk("R8", "lead before rr", int'(dqm_lead), apn ? 2 : 1);
        issue(C_RD, 1, 0);
        chk("R9", "rr pulse at t", int'(pre_start[0]), apn);
        if (apn != 0) chk("R9", "rr state at t", st(0), S_PRECH);
        tick(1);
        chk("R13", "rr pulse t+1", int'(pre_start[0]), 0);
        tick(1);
        chk("R5", "rr old beat t+2", obs_beat(), beat(1, 1, 0));
        if (apn == 0) chk("R11", "rr old bank open", st(0), S_OPEN);
        tick(1);
        chk("R5", "rr new beat t+3", obs_beat(), beat(1, 1, 1));
    endtask

    // read on bank 0 cut off by write on bank 1
    task automatic run_rw(input int apn);
        do_reset();
        issue(C_ACT, 0, 0); issue(C_ACT, 1, 0);
        issue(C_RD, 0, 1'(apn));
        chk("R8", "lead before rw", int'(dqm_lead), apn ? 2 : 1);
        issue(C_WR, 1, 0);
        chk("R6", "rw beat t", obs_beat(), beat(1, 0, 1));
        chk("R9", "rw state t", st(0), apn ? S_PRECH : S_OPEN);
        chk("R9", "rw pulse t", int'(pre_start[0]), apn);
        chk("R8", "lead after rw", int'(dqm_lead), 0);
        tick(2);
        chk("R6", "rw beat t+2", obs_beat(), beat(1, 0, 1));
        tick(1);
        chk("R11", "rw writer open", st(1), S_OPEN);
        tick(1);
        chk("R4", "rw window end", int'(dvalid), 0);
    endtask

    // write on bank 0 cut off by read on bank 1
    task automatic run_wr(input int apn);
        do_reset();
        issue(C_ACT, 0, 0); issue(C_ACT, 1, 0);
        issue(C_WR, 0, 1'(apn));
        tick(1);
        chk("R7", "wr old beat t-1", obs_beat(), beat(1, 0, 0));
        issue(C_RD, 1, 0);
        chk("R7", "wr no beat t", int'(dvalid), 0);
        chk("R10", "wr state t", st(0), apn ? S_WREC : S_OPEN);
        tick(1);
        chk("R10", "wr no pulse t+1", int'(pre_start[0]), 0);
        tick(1);
        chk("R10", "wr pulse t+2", int'(pre_start[0]), apn);
        tick(1);
        chk("R4", "wr read beat t+3", obs_beat(), beat(1, 1, 1));
    endtask

    // write on bank 0 cut off by write on bank 1
    task automatic run_ww(input int apn);
        do_reset();
        issue(C_ACT, 0, 0); issue(C_ACT, 1, 0);
        issue(C_WR, 0, 1'(apn));
        tick(1);
        chk("R7", "ww old beat t-1", obs_beat(), beat(1, 0, 0));
        issue(C_WR, 1, 0);
        chk("R7", "ww new beat t", obs_beat(), beat(1, 0, 1));
        tick(1);
        chk("R10", "ww state t+1", st(0), apn ? S_WREC : S_OPEN);
        tick(1);
        chk("R10", "ww pulse t+2", int'(pre_start[0]), apn);
    endtask

    function automatic int exp_legal(input logic [2:0] c, input int s);
        if (c == C_NOP) return 1;
        if (c == C_ACT) return (s == S_IDLE) ? 1 : 0;
        if (c == C_PRE) return (s == S_OPEN) ? 1 : 0;
        return 0;
    endfunction

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int mst[4];
        int mcnt[4];
        int seed;
        do_reset();
        for (int b = 0; b < 4; b++) chk("R1", "reset state", st(b), S_IDLE);
        chk("R1", "reset outs", int'(pre_start) + int'(dqm_lead) + int'(dvalid) + int'(illegal), 0);

        for (int k = 0; k < 2; k++) begin
            run_rr(k); run_rw(k); run_wr(k); run_ww(k);
        end

        // uninterrupted read with auto precharge, CL3
        do_reset();
        issue(C_ACT, 0, 0);
        issue(C_RD, 0, 1);
        tick(2);
        chk("R4", "rd cl3 t+2", int'(dvalid), 0);
        tick(1);
        chk("R4", "rd cl3 t+3", obs_beat(), beat(1, 1, 0));
        tick(2);
        chk("R11", "rd ap t+5", st(0), S_READ);
        tick(1);
        chk("R11", "rd ap t+6", st(0), S_PRECH);
        chk("R11", "rd ap pulse", int'(pre_start[0]), 1);
        tick(2);
        chk("R3", "back idle", st(0), S_IDLE);
        issue(C_RD, 0, 0);
        chk("R2", "read idle flag", int'(illegal), 1);
        chk("R3", "read idle state", st(0), S_IDLE);

        // uninterrupted read, CL2
        do_reset();
        cl3 = 1'b0;
        issue(C_ACT, 1, 0);
        issue(C_RD, 1, 0);
        tick(1);
        chk("R4", "rd cl2 t+1", int'(dvalid), 0);
        tick(1);
        chk("R4", "rd cl2 t+2", obs_beat(), beat(1, 1, 1));
        tick(3);
        chk("R4", "rd cl2 t+5", int'(dvalid), 1);
        chk("R11", "rd cl2 open", st(1), S_OPEN);
        tick(1);
        chk("R4", "rd cl2 t+6", int'(dvalid), 0);

        // uninterrupted write with auto precharge
        do_reset();
        issue(C_ACT, 2, 0);
        issue(C_WR, 2, 1);
        tick(3);
        chk("R11", "wr ap t+3", st(2), S_WREC);
        tick(1);
        chk("R11", "wr ap t+4", st(2), S_WREC);
        tick(1);
        chk("R11", "wr ap t+5", st(2), S_PRECH);
        chk("R13", "wr ap pulse", int'(pre_start[2]), 1);

        // burst stop
        do_reset();
        issue(C_ACT, 0, 0); issue(C_ACT, 1, 0);
        issue(C_RD, 0, 0);
        issue(C_BST, 1, 0);
        chk("R2", "bst wrong bank flag", int'(illegal), 1);
        chk("R12", "bst wrong bank keeps", st(0) * 10 + st(1), S_READ * 10 + S_OPEN);
        issue(C_BST, 0, 0);
        chk("R12", "bst state", st(0), S_OPEN);
        chk("R2", "bst legal flag", int'(illegal), 0);
        tick(1);
        chk("R12", "bst no beat", int'(dvalid), 0);
        issue(3'd6, 0, 0);
        chk("R2", "reserved code", int'(illegal), 1);

        // constrained random open/close/stop/reserved against a bench model
        do_reset();
        seed = $urandom(32'd2024);
        for (int b = 0; b < 4; b++) begin mst[b] = S_IDLE; mcnt[b] = 0; end
        for (int i = 0; i < 400; i++) begin
            logic [2:0] c;
            int rb, lg, ok;
            int pick = int'($urandom_range(0, 9));
            rb = int'($urandom_range(0, 3));
            c = (pick < 4) ? C_ACT : (pick < 7) ? C_PRE : (pick == 7) ? C_NOP :
                (pick == 8) ? C_BST : 3'd7;
            lg = exp_legal(c, mst[rb]);
            issue(c, rb, 1'($urandom_range(0, 1)));
            for (int b = 0; b < 4; b++) begin
                if (mst[b] == S_PRECH) begin
                    if (mcnt[b] == 0) mst[b] = S_IDLE;
                    else mcnt[b]--;
                end
            end
            if (lg == 1 && c == C_ACT) mst[rb] = S_OPEN;
            if (lg == 1 && c == C_PRE) begin mst[rb] = S_PRECH; mcnt[rb] = TRP - 1; end
            chk("R2", "random illegal", int'(illegal), 1 - lg);
            ok = 1;
            for (int b = 0; b < 4; b++) if (st(b) != mst[b]) ok = 0;
            chk("R3", "random states", ok, 1);
            chk("R13", "random pulse", int'(pre_start),
                (lg == 1 && c == C_PRE) ? (1 << rb) : 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule